// File: doc/BRIEF.md
# Memory-Mapped I/O Range Router with Per-Range Lock

This block steers memory-mapped I/O requests on a 40-bit physical address space to a destination node and a destination link. It keeps eight programmable windows. Each window is described by a lower-bound word and an upper-bound word, and both bounds are compared against address bits 39:16, so the windows have a 64 KB granularity. A request presents its address, a write flag and a flag that says whether it came from the processor. One cycle later the block reports whether any window claimed the request. For a claimed request it also reports the index of the winning window, the node and link taken from that window's upper-bound word, and whether a processor write must be issued as non-posted.

Each window has a lock bit. Once the lock bit is set, both words of that window become read-only until reset. A write aimed at a locked window is discarded and answered with a one-cycle error pulse. Each window also has a processor-exclusion bit, which hides the window from processor-originated requests while leaving it visible to all other requesters. The link code 3 is reserved, and a window that carries it never claims a request.

Software reaches the words through a small configuration port run by a two-state machine. The state CFG_IDLE waits for a request and moves to CFG_RESP on the clock edge that accepts one. In CFG_RESP the machine drives the acknowledge, the error flag and the read data. It then returns to CFG_IDLE unconditionally on the next edge. A requester holds its request until it sees the acknowledge, and it drops the request in the same cycle.

Top module: `mmio_range_router`

## Requirements
- R1: After reset all sixteen configuration words read as zero, and cfg_ack, cfg_err and rt_valid are low.
- R2: A cfg_req seen in CFG_IDLE is answered by cfg_ack high for exactly one cycle, starting one cycle later. During that cycle cfg_rdata shows the selected word as it stands after the access. In the lower-bound word, bit 0 is read enable, bit 1 is write enable, bit 2 is processor-exclude, bit 3 is lock and bits [31:8] are page bits 39:16. The bits in between read as zero.
- R3: In the upper-bound word, bits [2:0] are the node, bits [5:4] are the link, bit 7 is non-posted and bits [31:8] are page bits 39:16. Bits 3 and 6 read as zero.
- R4: Once a window's lock bit is set, writes to either of its two words leave both words unchanged. Only reset clears the lock.
- R5: cfg_err is high together with cfg_ack when the accepted access was a write to a locked window. At all other times cfg_err is low.
- R6: A window claims an address only when its lower page ≤ dec_addr[39:16] ≤ its upper page, with both bounds inclusive.
- R7: A read is claimed only by a window with read enable set, and a write only by a window with write enable set.
- R8: A window with processor-exclude set never claims a request that has dec_cpu high. It still claims requests that have dec_cpu low.
- R9: A window whose link field is 3 never claims any request.
- R10: When several windows claim a request, the lowest index wins and is reported on rt_index.
- R11: rt_nonposted is high only for a claimed request that is a processor write, where the winning window has its non-posted bit set.
- R12: rt_valid follows dec_valid one cycle later. On a claimed request, rt_node and rt_link come from the winning window. On a miss, rt_hit, rt_index, rt_node, rt_link and rt_nonposted are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration access request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_lim | input | 1 | 1 = upper-bound word, 0 = lower-bound word |
| cfg_idx | input | 3 | Window index |
| cfg_wdata | input | 32 | Write data |
| cfg_ack | output | 1 | Access answered (one cycle) |
| cfg_err | output | 1 | Write to a locked window was dropped |
| cfg_rdata | output | 32 | Selected word after the access |
| dec_valid | input | 1 | Decode request present |
| dec_addr | input | 40 | Request address |
| dec_write | input | 1 | Request is a write |
| dec_cpu | input | 1 | Request comes from the processor |
| rt_valid | output | 1 | Decode result present |
| rt_hit | output | 1 | A window claimed the request |
| rt_index | output | 3 | Index of the winning window |
| rt_node | output | 3 | Destination node |
| rt_link | output | 2 | Destination link |
| rt_nonposted | output | 1 | Processor write must be non-posted |

## Verification
If a stored word or lock bit goes wrong, the error shows on cfg_rdata in the acknowledge cycle of the next read of that word. It also shows on the routing outputs one cycle after the first request that falls into the affected window. If the lock state goes wrong, a dropped or accepted write shows on cfg_err in the same acknowledge cycle, and it shows again at the next read-back. The bench keeps its own model of all sixteen words and compares every output on every clock, so any such error is reported within one or two cycles of the access that exposes it.

// File: rtl/mmio_rr_pkg.sv
package mmio_rr_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 40;
    localparam int GRAN_W   = 16;
    localparam int PAGE_W   = ADDR_W - GRAN_W;
    localparam int PAGE_LSB = REG_W - PAGE_W;
    localparam int NODE_W   = 3;
    localparam int LINK_W   = 2;

    localparam logic [LINK_W-1:0] LINK_RSVD = '1;

    typedef enum logic [0:0] {
        CFG_IDLE = 1'b0,
        CFG_RESP = 1'b1
    } cfg_state_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              lock;
        logic              cpu_excl;
        logic              wr_en;
        logic              rd_en;
    } lo_word_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              nonposted;
        logic [LINK_W-1:0] link;
        logic [NODE_W-1:0] node;
    } hi_word_t;

    function automatic lo_word_t make_lo(input logic [REG_W-1:0] w);
        lo_word_t r;
        r.page     = w[PAGE_LSB +: PAGE_W];
        r.lock     = w[3];
        r.cpu_excl = w[2];
        r.wr_en    = w[1];
        r.rd_en    = w[0];
        return r;
    endfunction

    function automatic hi_word_t make_hi(input logic [REG_W-1:0] w);
        hi_word_t r;
        r.page      = w[PAGE_LSB +: PAGE_W];
        r.nonposted = w[7];
        r.link      = w[5:4];
        r.node      = w[2:0];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] lo_to_word(input lo_word_t v);
        logic [REG_W-1:0] w;
        w = '0;
        w[PAGE_LSB +: PAGE_W] = v.page;
        w[3] = v.lock;
        w[2] = v.cpu_excl;
        w[1] = v.wr_en;
        w[0] = v.rd_en;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] hi_to_word(input hi_word_t v);
        logic [REG_W-1:0] w;
        w = '0;
        w[PAGE_LSB +: PAGE_W] = v.page;
        w[7]   = v.nonposted;
        w[5:4] = v.link;
        w[2:0] = v.node;
        return w;
    endfunction

endpackage

// File: rtl/mmio_rr_regs.sv
module mmio_rr_regs
    import mmio_rr_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_req,
    input  logic                     cfg_wr,
    input  logic                     cfg_lim,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [REG_W-1:0]         cfg_wdata,
    output logic                     cfg_ack,
    output logic                     cfg_err,
    output logic [REG_W-1:0]         cfg_rdata,
    output lo_word_t [NUM_WIN-1:0]   lo_o,
    output hi_word_t [NUM_WIN-1:0]   hi_o
);

    cfg_state_e state_q, state_d;
    lo_word_t [NUM_WIN-1:0] lo_q;
    hi_word_t [NUM_WIN-1:0] hi_q;
    logic [IDX_W-1:0] sel_idx_q;
    logic             sel_lim_q;
    logic             err_q;
    logic             accept;
    logic             tgt_locked;
    logic             do_write;
    logic [NUM_WIN-1:0] lock_vec;
    logic             unused_rsvd;

    assign unused_rsvd = ^{cfg_wdata[6], cfg_wdata[PAGE_LSB-1:7]};

    assign accept     = (state_q == CFG_IDLE) && cfg_req;
    assign tgt_locked = lo_q[cfg_idx].lock;
    assign do_write   = accept && cfg_wr && !tgt_locked;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: if (cfg_req) state_d = CFG_RESP;
            CFG_RESP: state_d = CFG_IDLE;
        endcase
    end

    // storage and captured access attributes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_q      <= '0;
            sel_idx_q <= '0;
            sel_lim_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (accept) begin
                sel_idx_q <= cfg_idx;
                sel_lim_q <= cfg_lim;
            end
            err_q <= accept && cfg_wr && tgt_locked;
            if (do_write) begin
                if (cfg_lim) hi_q[cfg_idx] <= make_hi(cfg_wdata);
                else         lo_q[cfg_idx] <= make_lo(cfg_wdata);
            end
        end
    end

    // outputs
    always_comb begin
        cfg_ack   = 1'b0;
        cfg_err   = 1'b0;
        cfg_rdata = '0;
        unique case (state_q)
            CFG_IDLE: ;
            CFG_RESP: begin
                cfg_ack   = 1'b1;
                cfg_err   = err_q;
                cfg_rdata = sel_lim_q ? hi_to_word(hi_q[sel_idx_q])
                                      : lo_to_word(lo_q[sel_idx_q]);
            end
        endcase
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_lockv
        assign lock_vec[g] = lo_q[g].lock;
    end

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ack |=> !cfg_ack);

    assert_err_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_ack);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~lock_vec & $past(lock_vec)) == '0));

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_frozen
        assert_locked_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(lock_vec[g]) |-> ($stable(lo_q[g]) && $stable(hi_q[g])));
    end

endmodule

// File: rtl/mmio_rr_window.sv
module mmio_rr_window
    import mmio_rr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  lo_word_t          lo,
    input  hi_word_t          hi,
    input  logic [PAGE_W-1:0] page,
    input  logic              is_write,
    input  logic              is_cpu,
    output logic              claim
);

    logic in_range;
    logic dir_ok;
    logic origin_ok;
    logic link_ok;

    always_comb begin
        in_range  = (page >= lo.page) && (page <= hi.page);
        dir_ok    = is_write ? lo.wr_en : lo.rd_en;
        origin_ok = !(is_cpu && lo.cpu_excl);
        link_ok   = (hi.link != LINK_RSVD);
        claim     = in_range && dir_ok && origin_ok && link_ok;
    end

    assert_rsvd_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hi.link == LINK_RSVD) |-> !claim);

    assert_cpu_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cpu && lo.cpu_excl) |-> !claim);

endmodule

// File: rtl/mmio_rr_prio.sv
module mmio_rr_prio #(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] req,
    output logic [NUM_WIN-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx   = IDX_W'(i);
                any   = 1'b1;
            end
        end
    end

    assert_single_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant != '0) == (req != '0)));

    assert_winner_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[idx]);

endmodule

// File: rtl/mmio_range_router.sv
module mmio_range_router
    import mmio_rr_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_req,
    input  logic              cfg_wr,
    input  logic              cfg_lim,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_err,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_write,
    input  logic              dec_cpu,
    output logic              rt_valid,
    output logic              rt_hit,
    output logic [IDX_W-1:0]  rt_index,
    output logic [NODE_W-1:0] rt_node,
    output logic [LINK_W-1:0] rt_link,
    output logic              rt_nonposted
);

    lo_word_t [NUM_WIN-1:0] lo_w;
    hi_word_t [NUM_WIN-1:0] hi_w;
    logic [NUM_WIN-1:0]     claims;
    logic [NUM_WIN-1:0]     grant;
    logic [IDX_W-1:0]       win_idx;
    logic                   win_any;
    logic [PAGE_W-1:0]      req_page;
    logic                   unused_offset;
    hi_word_t               win_hi;

    assign req_page      = dec_addr[ADDR_W-1:GRAN_W];
    assign unused_offset = ^dec_addr[GRAN_W-1:0];

    mmio_rr_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_req   (cfg_req),
        .cfg_wr    (cfg_wr),
        .cfg_lim   (cfg_lim),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_ack   (cfg_ack),
        .cfg_err   (cfg_err),
        .cfg_rdata (cfg_rdata),
        .lo_o      (lo_w),
        .hi_o      (hi_w)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        mmio_rr_window u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .lo       (lo_w[g]),
            .hi       (hi_w[g]),
            .page     (req_page),
            .is_write (dec_write),
            .is_cpu   (dec_cpu),
            .claim    (claims[g])
        );
    end

    mmio_rr_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (claims),
        .grant (grant),
        .idx   (win_idx),
        .any   (win_any)
    );

    assign win_hi = hi_w[win_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_valid     <= 1'b0;
            rt_hit       <= 1'b0;
            rt_index     <= '0;
            rt_node      <= '0;
            rt_link      <= '0;
            rt_nonposted <= 1'b0;
        end else begin
            rt_valid <= dec_valid;
            if (dec_valid && win_any) begin
                rt_hit       <= 1'b1;
                rt_index     <= win_idx;
                rt_node      <= win_hi.node;
                rt_link      <= win_hi.link;
                rt_nonposted <= dec_write && dec_cpu && win_hi.nonposted;
            end else begin
                rt_hit       <= 1'b0;
                rt_index     <= '0;
                rt_node      <= '0;
                rt_link      <= '0;
                rt_nonposted <= 1'b0;
            end
        end
    end

    assert_result_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> rt_valid);

    assert_hit_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rt_hit |-> rt_valid);

    assert_np_only_on_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rt_nonposted |-> (rt_hit && rt_link != LINK_RSVD));

    assert_np_cpu_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !(dec_write && dec_cpu)) |=> !rt_nonposted);

endmodule

// File: tb/test_mmio_range_router.sv
module test_mmio_range_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 0, cfg_wr = 0, cfg_lim = 0;
    logic [2:0]  cfg_idx = 0;
    logic [31:0] cfg_wdata = 0;
    logic        cfg_ack, cfg_err;
    logic [31:0] cfg_rdata;
    logic        dec_valid = 0, dec_write = 0, dec_cpu = 0;
    logic [39:0] dec_addr = 0;
    logic        rt_valid, rt_hit, rt_nonposted;
    logic [2:0]  rt_index, rt_node;
    logic [1:0]  rt_link;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    mmio_range_router i_mmio_range_router (
        .clk(clk), .rst_n(rst_n),
        .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_lim(cfg_lim), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rdata(cfg_rdata),
        .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_write(dec_write), .dec_cpu(dec_cpu),
        .rt_valid(rt_valid), .rt_hit(rt_hit), .rt_index(rt_index), .rt_node(rt_node),
        .rt_link(rt_link), .rt_nonposted(rt_nonposted)
    );

    // behavioural model state
    logic [23:0] m_lo_page [8];
    logic [23:0] m_hi_page [8];
    logic        m_re [8], m_we [8], m_cx [8], m_lk [8], m_np [8];
    logic [2:0]  m_node [8];
    logic [1:0]  m_link [8];
    logic        m_busy;
    logic        e_ack, e_err, e_valid, e_hit, e_np;
    logic [31:0] e_rdata;
    logic [2:0]  e_idx, e_node;
    logic [1:0]  e_link;

    function automatic logic [31:0] m_word(input int i, input logic lim);
        if (lim) return {m_hi_page[i], m_np[i], 1'b0, m_link[i], 1'b0, m_node[i]};
        return {m_lo_page[i], 4'b0, m_lk[i], m_cx[i], m_we[i], m_re[i]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_lo_page[i] = 0; m_hi_page[i] = 0; m_re[i] = 0; m_we[i] = 0;
                m_cx[i] = 0; m_lk[i] = 0; m_np[i] = 0; m_node[i] = 0; m_link[i] = 0;
            end
            m_busy = 0; e_ack = 0; e_err = 0; e_rdata = 0;
            e_valid = 0; e_hit = 0; e_idx = 0; e_node = 0; e_link = 0; e_np = 0;
        end else begin
            // decode result, from the words as they were before this edge
            e_valid = dec_valid; e_hit = 0; e_idx = 0; e_node = 0; e_link = 0; e_np = 0;
            if (dec_valid) begin
                for (int i = 0; i < 8; i++) begin
                    int pg;
                    pg = int'(dec_addr[39:16]);
                    if (!e_hit && pg >= int'(m_lo_page[i]) && pg <= int'(m_hi_page[i])
                        && (dec_write ? m_we[i] : m_re[i]) && !(dec_cpu && m_cx[i])
                        && m_link[i] != 2'd3) begin
                        e_hit = 1; e_idx = 3'(i); e_node = m_node[i]; e_link = m_link[i];
                        e_np = dec_write && dec_cpu && m_np[i];
                    end
                end
            end
            // configuration port
            if (m_busy) begin
                m_busy = 0; e_ack = 0; e_err = 0; e_rdata = 0;
            end else if (cfg_req) begin
                int k;
                k = int'(cfg_idx);
                m_busy = 1; e_ack = 1; e_err = 0;
                if (cfg_wr && m_lk[k]) e_err = 1;
                else if (cfg_wr && cfg_lim) begin
                    m_hi_page[k] = cfg_wdata[31:8]; m_np[k] = cfg_wdata[7];
                    m_link[k] = cfg_wdata[5:4]; m_node[k] = cfg_wdata[2:0];
                end else if (cfg_wr) begin
                    m_lo_page[k] = cfg_wdata[31:8]; m_lk[k] = cfg_wdata[3];
                    m_cx[k] = cfg_wdata[2]; m_we[k] = cfg_wdata[1]; m_re[k] = cfg_wdata[0];
                end
                e_rdata = m_word(k, cfg_lim);
            end else begin
                e_ack = 0; e_err = 0; e_rdata = 0;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 ack", 32'(cfg_ack), 32'(e_ack));
            check("R5 err", 32'(cfg_err), 32'(e_err));
            check("R2 R3 R4 rdata", cfg_rdata, e_rdata);
            check("R12 rt_valid", 32'(rt_valid), 32'(e_valid));
            check("R6 R7 R8 R9 hit", 32'(rt_hit), 32'(e_hit));
            check("R10 index", 32'(rt_index), 32'(e_idx));
            check("R12 node", 32'(rt_node), 32'(e_node));
            check("R12 link", 32'(rt_link), 32'(e_link));
            check("R11 nonposted", 32'(rt_nonposted), 32'(e_np));
        end
    end

    task automatic cfg_op(input logic wr, input logic lim, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_req = 1; cfg_wr = wr; cfg_lim = lim; cfg_idx = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_req = 0; cfg_wr = 0; cfg_wdata = 0;
        @(negedge clk);
    endtask

    task automatic dec_op(input logic [23:0] page, input logic wr, input logic cpu);
        @(negedge clk);
        dec_valid = 1; dec_addr = {page, 16'h5a3c}; dec_write = wr; dec_cpu = cpu;
        @(negedge clk);
        dec_valid = 0; dec_addr = 0; dec_write = 0; dec_cpu = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 ack in reset", 32'(cfg_ack), 0);
        check("R1 err in reset", 32'(cfg_err), 0);
        check("R1 rt_valid in reset", 32'(rt_valid), 0);
        rst_n = 1;
        cfg_op(0, 0, 0, 0);
        cfg_op(0, 1, 7, 0);
        // program windows: upper words first, then lower words
        cfg_op(1, 1, 0, {24'h000100, 8'h81});   // node 1, link 0, np
        cfg_op(1, 0, 0, {24'h000010, 8'hF3});   // rd+wr, reserved bits set
        cfg_op(1, 1, 1, {24'h000200, 8'h5A});   // node 2, link 1, rsvd bits
        cfg_op(1, 0, 1, {24'h000050, 8'h06});   // wr only, cpu excluded
        cfg_op(1, 1, 2, {24'h0003FF, 8'h35});   // link 3 reserved
        cfg_op(1, 0, 2, {24'h000300, 8'h03});
        cfg_op(1, 1, 3, {24'h0003FF, 8'h26});   // node 6, link 2
        cfg_op(1, 0, 3, {24'h000300, 8'h03});
        for (int i = 0; i < 4; i++) begin
            cfg_op(0, 0, i, 0);
            cfg_op(0, 1, i, 0);
        end
        // R6 boundaries, R7 direction, R8 origin, R9 reserved link, R10 priority, R11
        dec_op(24'h000010, 0, 1);
        dec_op(24'h000100, 0, 1);
        dec_op(24'h00000F, 0, 1);
        dec_op(24'h000101, 0, 0);
        dec_op(24'h000101, 1, 0);
        dec_op(24'h000101, 1, 1);
        dec_op(24'h000080, 1, 1);
        dec_op(24'h000080, 1, 0);
        dec_op(24'h000080, 0, 1);
        dec_op(24'h000350, 0, 1);
        dec_op(24'h000201, 1, 0);
        // R4 R5: lock window 0, then try to change it
        cfg_op(1, 0, 0, {24'h000010, 8'h0B});
        cfg_op(1, 1, 0, {24'h000FFF, 8'h12});
        cfg_op(1, 0, 0, {24'h000000, 8'h03});
        cfg_op(0, 1, 0, 0);
        cfg_op(1, 1, 1, {24'h000210, 8'h13});
        dec_op(24'h000080, 1, 1);
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom_range(0, 3));
            if (r == 0)
                cfg_op(1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                       {14'd0, 10'($urandom), 8'($urandom)});
            else if (r == 1)
                cfg_op(0, 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), 0);
            else
                dec_op(24'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)));
        end
        // R4: reset clears locks
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1 rt_valid after reset", 32'(rt_valid), 0);
        rst_n = 1;
        cfg_op(1, 1, 0, {24'h000123, 8'h07});
        cfg_op(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule